// File: doc/BRIEF.md
# Four-Channel APB Pulse-Width Modulator

This peripheral drives four independent pulse-width outputs from a single APB clock. Each channel has two 32-bit settings. One is the cycle length in clock ticks. The other is the number of ticks at the start of each cycle during which the output is high. Software programs both over an APB slave port, which always answers with zero wait states and never signals an error.

The counters do not pick up new settings as soon as they are written. Each running channel keeps a working copy of its settings and refreshes it only when the current cycle ends, so a reprogrammed waveform never shows a truncated or stretched cycle. A channel whose cycle length is zero is stopped and parks its output high. This is also the state of every channel after reset. Once a nonzero cycle length appears, a stopped channel starts at once rather than waiting for a boundary.

For a glitch-free start from the stopped state, write the high-time setting first and the cycle length second.

Top module: `pwm_ctrl`

## Requirements
- R1: After reset every setting reads zero and every bit of `pwm_o` is 1.
- R2: Channel c has its high-time setting at byte offset 8*c and its cycle-length setting at byte offset 8*c+4. A read returns the value most recently written there, not the copy the counter is using.
- R3: While a channel runs with cycle length P>0 and high time H<P, its output is 1 for the first H ticks of every P-tick cycle and 0 for the remaining P-H ticks.
- R4: With a nonzero cycle length P and a high time H>=P, the output is 1 on every tick.
- R5: With a nonzero cycle length and a high time of 0, the output is 0 on every tick.
- R6: A cycle length of 0 stops the channel at the end of its current cycle, and its output then stays 1 whatever the high-time setting holds.
- R7: A setting written while a channel runs has no effect on its output until the cycle in progress has completed all of its ticks.
- R8: A stopped channel starts when its cycle length becomes nonzero. In the clock cycle that follows the write, the output is still 1. In the next clock cycle it shows tick 0 of the new cycle.
- R9: An access is outside the map when its word offset is 0x20 or above, or when paddr_i[1:0] is nonzero. Such an access reads zero and its write changes no setting. `pready_o` is always 1 and `pslverr_o` is always 0.
- R10: The channels count independently: the settings of one channel do not change the waveform of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB clock, also the counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, held at 1 |
| pslverr_o | output | 1 | APB error, held at 0 |
| pwm_o | output | NUM_CH | One waveform output per channel |

## Verification
Three kinds of internal fault show at the ports, each on a known schedule. A counter that wraps at the wrong count, or a high-time compare that is off by one, changes the number of high ticks in any window that is a whole number of cycles long. The bench measures that count against min(H,P) per cycle. If the working copy is refreshed mid-cycle, the output turns high within one tick of the write instead of at the next boundary. A bad start or stop flag shows either as a missing low tick two clocks after the period write or as a channel that never parks high.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W = 32;

  typedef enum logic {
    FLD_HI  = 1'b0,
    FLD_PER = 1'b1
  } fld_e;

  typedef struct packed {
    logic [DATA_W-1:0] hi;
    logic [DATA_W-1:0] per;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output chan_cfg_t         cfg_o [NUM_CH]
);
  localparam int NUM_REG = 2 * NUM_CH;
  localparam int IDX_W   = $clog2(NUM_REG);
  localparam int WRD_W   = ADDR_W - 2;

  logic [WRD_W-1:0] word;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             wr_en;
  chan_cfg_t        cfg_q [NUM_CH];

  assign word  = paddr_i[ADDR_W-1:2];
  assign hit   = (paddr_i[1:0] == 2'b00) && (word < WRD_W'(NUM_REG));
  assign idx   = word[IDX_W-1:0];
  assign wr_en = psel_i & penable_i & pwrite_i & hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[c] <= '0;
      end else if (wr_en && idx[IDX_W-1:1] == (IDX_W-1)'(c)) begin
        if (fld_e'(idx[0]) == FLD_PER) cfg_q[c].per <= pwdata_i;
        else                           cfg_q[c].hi  <= pwdata_i;
      end
    end
    assign cfg_o[c] = cfg_q[c];
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i && hit) begin
      prdata_o = (fld_e'(idx[0]) == FLD_PER) ? cfg_q[idx[IDX_W-1:1]].per
                                             : cfg_q[idx[IDX_W-1:1]].hi;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cfg_t cfg_i,
  output logic      run_o,
  output logic      pwm_o
);
  logic              run_q;
  logic [DATA_W-1:0] cnt_q;
  chan_cfg_t         sh_q;
  logic              wrap;

  assign wrap = (cnt_q == sh_q.per - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!run_q) begin
      // idle: launch as soon as a nonzero period is present
      if (cfg_i.per != '0) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        sh_q  <= cfg_i;
      end
    end else if (wrap) begin
      cnt_q <= '0;
      sh_q  <= cfg_i;
      run_q <= (cfg_i.per != '0);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_o = run_q;
  assign pwm_o = !run_q || (cnt_q < sh_q.hi);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [NUM_CH-1:0] pwm_o
);
  chan_cfg_t         cfg [NUM_CH];
  logic [NUM_CH-1:0] run_w;

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  pwm_regs #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .cfg_o    (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cfg_i (cfg[c]),
      .run_o (run_w[c]),
      .pwm_o (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       pwdata_i,
  input logic [31:0]       prdata_o,
  input logic              pready_o,
  input logic              pslverr_o,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] run_w
);
  localparam int NUM_REG = 2 * NUM_CH;
  localparam int IDX_W   = $clog2(NUM_REG);
  localparam int WRD_W   = ADDR_W - 2;

  logic [WRD_W-1:0] word;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [31:0]      mir_q [NUM_REG];
  logic             seen_q;

  assign word = paddr_i[ADDR_W-1:2];
  assign hit  = (paddr_i[1:0] == 2'b00) && (word < WRD_W'(NUM_REG));
  assign idx  = word[IDX_W-1:0];

  // shadow of what software wrote, built only from bus traffic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REG; i++) mir_q[i] <= '0;
    end else if (psel_i && penable_i && pwrite_i && hit) begin
      mir_q[idx] <= pwdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (!seen_q) AST_RESET_OUT_HIGH: assert (pwm_o == '1); // R1
    end
  end

  AST_BUS_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o); // R9

  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && !hit) |-> (prdata_o == '0)); // R9

  AST_READBACK_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && hit) |-> (prdata_o == mir_q[idx])); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ast
    AST_IDLE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[c] && mir_q[2*c+1] != '0) |=> run_w[c]); // R8
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .pwdata_i (pwdata_i),
  .prdata_o (prdata_o),
  .pready_o (pready_o),
  .pslverr_o(pslverr_o),
  .pwm_o    (pwm_o),
  .run_w    (run_w)
);

// File: tb/tb_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_ctrl;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 12;
  localparam int WIN    = 60;
  localparam int NV     = 9;
  // {channel, high time, period, expected high ticks in WIN}
  localparam int VEC [NV][4] = '{
    '{0, 3, 10, 18},  // R3
    '{1, 6,  6, 60},  // R4 high == period
    '{2, 9,  5, 60},  // R4 high > period
    '{3, 0,  4,  0},  // R5
    '{0, 1, 12,  5},  // R3
    '{1, 7,  0, 60},  // R6 period zero, high nonzero
    '{2, 2,  3, 40},  // R3
    '{3, 0,  1,  0},  // R5 one-tick period
    '{0, 1,  2, 30}   // R3
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready, pslverr;
  logic [NUM_CH-1:0] pwm;
  int                n_run = 0, n_fail = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  pwm_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .pwm_o(pwm)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge right after the write edge
  task automatic apb_wr(input int addr, input int data);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    paddr = ADDR_W'(addr); pwdata = 32'(data);
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input int addr, output logic [31:0] d, output logic err);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = ADDR_W'(addr);
    @(negedge clk); penable = 1'b1;
    d = prdata; err = pslverr | ~pready;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic meas(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); hi += int'(pwm[ch]); end
  endtask

  initial begin
    logic [31:0] d;
    logic        e;
    int          h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs high after reset", pwm, 4'hF);
    for (int a = 0; a < 8; a++) begin
      apb_rd(a * 4, d, e);
      chk("R1 register zero after reset", d, 0);
    end

    // table walk: high first, then period, settle, count high ticks
    for (int v = 0; v < NV; v++) begin
      apb_wr(VEC[v][0] * 8, VEC[v][1]);
      apb_wr(VEC[v][0] * 8 + 4, VEC[v][2]);
      repeat (40) @(negedge clk);
      meas(VEC[v][0], WIN, h);
      chk($sformatf("R3/R4/R5/R6 vector %0d high ticks", v), h, VEC[v][3]);
      apb_rd(VEC[v][0] * 8, d, e);
      chk("R2 high-time readback", d, VEC[v][1]);
      apb_rd(VEC[v][0] * 8 + 4, d, e);
      chk("R2 period readback", d, VEC[v][2]);
    end

    // R10: all four counted together against their own settings
    begin
      int c0, c1, c2, c3;
      c0 = 0; c1 = 0; c2 = 0; c3 = 0;
      repeat (WIN) begin
        @(negedge clk);
        c0 += int'(pwm[0]); c1 += int'(pwm[1]);
        c2 += int'(pwm[2]); c3 += int'(pwm[3]);
      end
      chk("R10 ch0", c0, 30);
      chk("R10 ch1", c1, 60);
      chk("R10 ch2", c2, 40);
      chk("R10 ch3", c3, 0);
    end

    // R9: out-of-map and misaligned accesses
    apb_wr(32'h20, 32'h0000_DEAD);
    apb_rd(32'h20, d, e);
    chk("R9 read beyond map", d, 0);
    chk("R9 no error", e, 0);
    apb_wr(32'h01, 50);
    apb_rd(32'h01, d, e);
    chk("R9 misaligned read", d, 0);
    apb_rd(32'h00, d, e);
    chk("R9 misaligned write ignored", d, 1);
    apb_rd(32'h1C, d, e);
    chk("R9 last register untouched", d, 1);

    // R8: stop ch3, then launch with high time 0
    apb_wr(32'h1C, 0);
    repeat (5) @(negedge clk);
    chk("R6 ch3 parked high", pwm[3], 1);
    apb_wr(32'h1C, 8);
    chk("R8 still high after write", pwm[3], 1);
    @(negedge clk);
    chk("R8 first tick low", pwm[3], 0);

    // R7: ch1 is stopped; launch high=5 period=20, then raise high mid-cycle
    apb_wr(32'h08, 5);
    apb_wr(32'h0C, 20);
    repeat (6) @(negedge clk);
    chk("R3 low phase before update", pwm[1], 0);
    apb_wr(32'h08, 15);
    meas(1, 12, h);
    chk("R7 old high time kept to cycle end", h, 0);
    meas(1, 15, h);
    chk("R7 new high time after boundary", h, 15);
    @(negedge clk);
    chk("R7 low after new high phase", pwm[1], 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule